// File: doc/BRIEF.md
# Cached Page Read Sequencer

This block models the control side of one flash die serving cached page reads. A host writes opcode bytes and address bytes into it. The block keeps two page registers: an array-side data register and a host-side cache register. It runs the array fetches and the register-to-register copies for a single read, a sequential cached read, a random cached read and a final cached read. Its two ready flags tell the host whether the die is fully busy, whether it is busy with a cache operation, or whether it is idle.

The host reads back the page number held in the cache register and a column pointer. The pointer advances on each data output request and can be moved with a column-change sequence. Busy intervals are plain cycle counts, set by parameters. The legal command set narrows while the die is busy, and the block flags any opcode that is not allowed in the current state. A sequential fetch cannot run past the last page of the die; such an attempt is flagged and rejected.

Top module: `cache_read_seq`

## Requirements
- R1: The sequence 00h, NCOL column bytes, NROW row bytes (each field least significant byte first, column before row), 30h is a page read. In the cycle after 30h is accepted, rdy and ardy both drop to 0. They stay 0 for exactly T_R cycles and then both return to 1. At that point cache_page equals the row and col_ptr equals the given column.
- R2: Opcode 31h sets the data register to fetch the row after the last row requested. rdy and ardy are both 0 for T_RCBSY cycles. When rdy rises, cache_page shows the page the data register held, and col_ptr is 0. ardy then stays 0 for T_R more cycles while the fetch completes.
- R3: 00h, address bytes, 31h behaves like R2 but fetches the addressed row. The column bytes are ignored and col_ptr restarts at 0.
- R4: Opcode 3Fh is accepted only when both flags are 1. The die is fully busy for T_RCBSY cycles. Both flags then return to 1, cache_page shows the data register page and col_ptr is 0.
- R5: Each dout_req advances col_ptr by one. The sequence 05h, NCOL column bytes, E0h loads col_ptr.
- R6: A loaded column above PAGE_LEN-1, or an advance taken at PAGE_LEN-1, leaves col_ptr at PAGE_LEN-1. In that case col_err is 1 for the one following cycle.
- R7: While rdy=0, only 70h, 78h and FFh are accepted. Any other opcode raises cmd_err for one cycle and leaves the busy timing untouched.
- R8: While rdy=1 and ardy=0, 30h and 3Fh raise cmd_err. 00h, 05h, E0h, 31h, 70h, 78h and FFh are accepted.
- R9: 31h is accepted while the die is cache-busy. The full-busy phase then lasts at least T_RCBSY cycles and until the fetch in progress ends. The cache register then shows the page that fetch brought in.
- R10: The row is {block, page}, with a 6-bit page field in the low bits. A sequential fetch after page 63 of block b goes to page 0 of block b+1.
- R11: A 31h issued when the last row requested is the die's final row raises lun_err for one cycle. The command is dropped: the flags and cache_page do not change.
- R12: Opcode FFh is accepted in every state. In the next cycle rdy=ardy=1, col_ptr=0 and cache_vld=0. cache_vld becomes 1 when a read or a cache copy completes.
- R13: An unknown opcode, an address byte that no sequence expects, a 30h without a complete 00h address prefix, or an E0h without a complete 05h prefix each raise cmd_err for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Opcode byte present this cycle |
| cmd_byte | input | 8 | Opcode byte |
| addr_valid | input | 1 | Address byte present this cycle (ignored when cmd_valid is 1) |
| addr_byte | input | 8 | Address byte |
| dout_req | input | 1 | One data output request; advances the column |
| rdy | output | 1 | 0 while the die is fully busy |
| ardy | output | 1 | 0 while any array activity is in progress |
| cache_vld | output | 1 | Cache register holds a page |
| cache_page | output | PAGE_BITS+BLK_BITS | Row held in the cache register |
| col_ptr | output | $clog2(PAGE_LEN) | Column pointer for data output |
| cmd_err | output | 1 | One-cycle flag for an illegal or malformed opcode or address byte |
| lun_err | output | 1 | One-cycle flag for a sequential fetch past the die end |
| col_err | output | 1 | One-cycle flag for column saturation |

## Verification
The bench builds the block with two block-address bits, which gives 256 rows, and a 40-byte page. With one column byte and one row byte, every row of the die can be reached by sequential fetches within a few thousand cycles. A single sweep therefore crosses every block boundary and runs into the die end. T_R=7 and T_RCBSY=3 are short and distinct, so every flag transition can be counted cycle by cycle. The 40-byte page lets both column saturation paths be reached with one address byte.

// File: rtl/crs_pkg.sv
package crs_pkg;

  // ready level encoded as {rdy, ardy}
  typedef enum logic [1:0] {
    LV_FULL  = 2'b00,
    LV_CACHE = 2'b10,
    LV_READY = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    ST_READY,
    ST_ARRAY,
    ST_RCBSY,
    ST_CACHE
  } st_e;

  typedef enum logic [2:0] {
    DS_IDLE,
    DS_ADDR_RD,
    DS_WAIT_RD,
    DS_ADDR_COL,
    DS_WAIT_COL
  } ds_e;

  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_CONF_RD = 8'h30;
  localparam logic [7:0] OP_SEQ     = 8'h31;
  localparam logic [7:0] OP_LAST    = 8'h3F;
  localparam logic [7:0] OP_COLSEL  = 8'h05;
  localparam logic [7:0] OP_COLCONF = 8'hE0;
  localparam logic [7:0] OP_STAT    = 8'h70;
  localparam logic [7:0] OP_STATX   = 8'h78;
  localparam logic [7:0] OP_RESET   = 8'hFF;

  // opcode admissible in a ready level (prefix checks are separate)
  function automatic logic op_legal(lvl_e lv, logic [7:0] op);
    logic always_ok, cache_ok, ready_ok;
    always_ok = (op == OP_STAT) || (op == OP_STATX) || (op == OP_RESET);
    cache_ok  = (op == OP_READ) || (op == OP_SEQ) ||
                (op == OP_COLSEL) || (op == OP_COLCONF);
    ready_ok  = (op == OP_CONF_RD) || (op == OP_LAST);
    case (lv)
      LV_FULL:  return always_ok;
      LV_CACHE: return always_ok || cache_ok;
      default:  return always_ok || cache_ok || ready_ok;
    endcase
  endfunction

  // column clamp to the last valid column
  function automatic logic [31:0] col_clamp(logic [31:0] v, logic [31:0] last);
    return (v > last) ? last : v;
  endfunction

  // successor of a {block,page} row; carry from page into block is natural
  function automatic logic [31:0] row_succ(logic [31:0] r);
    return r + 32'd1;
  endfunction

endpackage

// File: rtl/crs_cmd_decode.sv
module crs_cmd_decode
  import crs_pkg::*;
#(
  parameter int NCOL  = 2,
  parameter int NROW  = 3,
  parameter int ROW_W = 18,
  localparam int CV_W  = NCOL * 8,
  localparam int NADDR = NCOL + NROW,
  localparam int AB_W  = NADDR * 8,
  localparam int AC_W  = $clog2(NADDR + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  input  logic             addr_valid,
  input  logic [7:0]       addr_byte,
  input  lvl_e             lvl,
  output logic             ev_read,
  output logic             ev_seq,
  output logic             ev_rand,
  output logic             ev_last,
  output logic             ev_colset,
  output logic             ev_reset,
  output logic             ev_bad,
  output logic [ROW_W-1:0] ev_row,
  output logic [CV_W-1:0]  ev_col
);

  ds_e             ds, ds_n;
  logic [AC_W-1:0] acnt;
  logic [AB_W-1:0] abuf;
  logic            collecting;
  logic            ok;

  assign collecting = (ds == DS_ADDR_RD) || (ds == DS_ADDR_COL);
  assign ok         = op_legal(lvl, cmd_byte);
  assign ev_row     = abuf[CV_W +: ROW_W];
  assign ev_col     = abuf[CV_W-1:0];

  always_comb begin
    ds_n      = ds;
    ev_read   = 1'b0;
    ev_seq    = 1'b0;
    ev_rand   = 1'b0;
    ev_last   = 1'b0;
    ev_colset = 1'b0;
    ev_reset  = 1'b0;
    ev_bad    = 1'b0;
    if (cmd_valid) begin
      ds_n = DS_IDLE;
      if (!ok) begin
        ev_bad = 1'b1;
      end else begin
        case (cmd_byte)
          OP_READ:    ds_n = DS_ADDR_RD;
          OP_CONF_RD: if (ds == DS_WAIT_RD) ev_read = 1'b1; else ev_bad = 1'b1;
          OP_SEQ:     if (ds == DS_WAIT_RD) ev_rand = 1'b1; else ev_seq = 1'b1;
          OP_LAST:    ev_last = 1'b1;
          OP_COLSEL:  ds_n = DS_ADDR_COL;
          OP_COLCONF: if (ds == DS_WAIT_COL) ev_colset = 1'b1; else ev_bad = 1'b1;
          OP_RESET:   ev_reset = 1'b1;
          default:    ;
        endcase
      end
    end else if (addr_valid) begin
      case (ds)
        DS_ADDR_RD:  if (acnt == AC_W'(NADDR - 1)) ds_n = DS_WAIT_RD;
        DS_ADDR_COL: if (acnt == AC_W'(NCOL - 1))  ds_n = DS_WAIT_COL;
        default: begin
          ev_bad = 1'b1;
          ds_n   = DS_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds   <= DS_IDLE;
      acnt <= '0;
      abuf <= '0;
    end else begin
      ds <= ds_n;
      if (cmd_valid) begin
        acnt <= '0;
      end else if (addr_valid && collecting) begin
        abuf[acnt*8 +: 8] <= addr_byte;
        acnt <= acnt + 1'b1;
      end
    end
  end

  a_r13_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_read, ev_seq, ev_rand, ev_last, ev_colset, ev_reset, ev_bad}));

  a_r13_stray_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !cmd_valid && ds == DS_IDLE) |-> ev_bad);

endmodule

// File: rtl/crs_col_ptr.sv
module crs_col_ptr
  import crs_pkg::*;
#(
  parameter int PAGE_LEN = 2112,
  parameter int COL_W    = 12,
  parameter int CV_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CV_W-1:0]  load_val,
  input  logic             step,
  output logic [COL_W-1:0] col,
  output logic             sat_err
);

  localparam logic [COL_W-1:0] LAST_C = COL_W'(PAGE_LEN - 1);
  localparam logic [31:0]      LAST_W = 32'(PAGE_LEN - 1);

  logic [31:0] clamped;
  logic        over;

  assign clamped = col_clamp(32'(load_val), LAST_W);
  assign over    = 32'(load_val) > LAST_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col     <= '0;
      sat_err <= 1'b0;
    end else if (load) begin
      col     <= COL_W'(clamped);
      sat_err <= over;
    end else if (step) begin
      if (col == LAST_C) begin
        sat_err <= 1'b1;
      end else begin
        col     <= col + 1'b1;
        sat_err <= 1'b0;
      end
    end else begin
      sat_err <= 1'b0;
    end
  end

  a_r6_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    col <= LAST_C);

  a_r6_err_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    sat_err |-> (col == LAST_C));

endmodule

// File: rtl/cache_read_seq.sv
module cache_read_seq
  import crs_pkg::*;
#(
  parameter int PAGE_BITS = 6,
  parameter int BLK_BITS  = 12,
  parameter int PAGE_LEN  = 2112,
  parameter int T_R       = 1000,
  parameter int T_RCBSY   = 150,
  localparam int ROW_W  = PAGE_BITS + BLK_BITS,
  localparam int NROW   = (ROW_W + 7) / 8,
  localparam int COL_W  = $clog2(PAGE_LEN),
  localparam int NCOL   = (COL_W + 7) / 8,
  localparam int CV_W   = NCOL * 8,
  localparam int TR_W   = $clog2(T_R + 1),
  localparam int RCB_W  = $clog2(T_RCBSY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  input  logic             addr_valid,
  input  logic [7:0]       addr_byte,
  input  logic             dout_req,
  output logic             rdy,
  output logic             ardy,
  output logic             cache_vld,
  output logic [ROW_W-1:0] cache_page,
  output logic [COL_W-1:0] col_ptr,
  output logic             cmd_err,
  output logic             lun_err,
  output logic             col_err
);

  // decoder events (named for the assertions)
  logic             ev_read, ev_seq, ev_rand, ev_last, ev_colset, ev_reset, ev_bad;
  logic [ROW_W-1:0] ev_row;
  logic [CV_W-1:0]  ev_col;

  st_e              st;
  lvl_e             lvl;
  logic             arr_busy;
  logic [TR_W-1:0]  arr_cnt;
  logic [RCB_W-1:0] rcb_cnt;
  logic [ROW_W-1:0] arr_pg, data_pg, last_tgt, pend_tgt;
  logic [CV_W-1:0]  rd_col;
  logic             op_last;

  logic             arr_done, tr_done, rcb_end, seq_wrap, seq_go;
  logic [ROW_W-1:0] seq_row, cache_tgt;
  logic             col_load;
  logic [CV_W-1:0]  col_val;

  always_comb begin
    case (st)
      ST_READY: lvl = LV_READY;
      ST_CACHE: lvl = LV_CACHE;
      default:  lvl = LV_FULL;
    endcase
  end

  assign rdy  = lvl[1];
  assign ardy = lvl[0];

  crs_cmd_decode #(.NCOL(NCOL), .NROW(NROW), .ROW_W(ROW_W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .addr_valid(addr_valid), .addr_byte(addr_byte),
    .lvl(lvl),
    .ev_read(ev_read), .ev_seq(ev_seq), .ev_rand(ev_rand), .ev_last(ev_last),
    .ev_colset(ev_colset), .ev_reset(ev_reset), .ev_bad(ev_bad),
    .ev_row(ev_row), .ev_col(ev_col)
  );

  assign arr_done  = arr_busy && (arr_cnt == TR_W'(T_R - 1));
  assign tr_done   = (st == ST_ARRAY) && arr_done;
  assign rcb_end   = (st == ST_RCBSY) && (rcb_cnt == RCB_W'(T_RCBSY - 1)) && !arr_busy;
  assign seq_wrap  = (last_tgt == {ROW_W{1'b1}});
  assign seq_go    = ev_seq && !seq_wrap;
  assign seq_row   = ROW_W'(row_succ(32'(last_tgt)));
  assign cache_tgt = seq_go ? seq_row : ev_row;

  // column pointer control
  assign col_load = ev_reset || ev_colset || tr_done || rcb_end;
  always_comb begin
    if (ev_reset || rcb_end) col_val = '0;
    else if (ev_colset)      col_val = ev_col;
    else                     col_val = rd_col;
  end

  crs_col_ptr #(.PAGE_LEN(PAGE_LEN), .COL_W(COL_W), .CV_W(CV_W)) u_col (
    .clk(clk), .rst_n(rst_n),
    .load(col_load), .load_val(col_val), .step(dout_req),
    .col(col_ptr), .sat_err(col_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_READY;
      arr_busy   <= 1'b0;
      arr_cnt    <= '0;
      rcb_cnt    <= '0;
      arr_pg     <= '0;
      data_pg    <= '0;
      last_tgt   <= '0;
      pend_tgt   <= '0;
      rd_col     <= '0;
      op_last    <= 1'b0;
      cache_page <= '0;
      cache_vld  <= 1'b0;
      cmd_err    <= 1'b0;
      lun_err    <= 1'b0;
    end else begin
      cmd_err <= ev_bad;
      lun_err <= ev_seq && seq_wrap;
      if (ev_reset) begin
        st        <= ST_READY;
        arr_busy  <= 1'b0;
        arr_cnt   <= '0;
        rcb_cnt   <= '0;
        cache_vld <= 1'b0;
      end else begin
        // array fetch engine
        if (arr_busy) begin
          if (arr_done) begin
            arr_busy <= 1'b0;
            data_pg  <= arr_pg;
          end else begin
            arr_cnt <= arr_cnt + 1'b1;
          end
        end
        if (st == ST_RCBSY && rcb_cnt != RCB_W'(T_RCBSY - 1))
          rcb_cnt <= rcb_cnt + 1'b1;

        case (st)
          ST_READY, ST_CACHE: begin
            if (st == ST_CACHE && arr_done) st <= ST_READY;
            if (ev_read) begin
              arr_busy <= 1'b1;
              arr_cnt  <= '0;
              arr_pg   <= ev_row;
              last_tgt <= ev_row;
              rd_col   <= ev_col;
              st       <= ST_ARRAY;
            end else if (seq_go || ev_rand || ev_last) begin
              st      <= ST_RCBSY;
              rcb_cnt <= '0;
              op_last <= ev_last;
              if (!ev_last) begin
                pend_tgt <= cache_tgt;
                last_tgt <= cache_tgt;
              end
            end
          end
          ST_ARRAY: begin
            if (arr_done) begin
              cache_page <= arr_pg;
              cache_vld  <= 1'b1;
              st         <= ST_READY;
            end
          end
          default: begin
            if (rcb_end) begin
              cache_page <= data_pg;
              cache_vld  <= 1'b1;
              if (op_last) begin
                st <= ST_READY;
              end else begin
                arr_busy <= 1'b1;
                arr_cnt  <= '0;
                arr_pg   <= pend_tgt;
                st       <= ST_CACHE;
              end
            end
          end
        endcase
      end
    end
  end

  a_r1_read_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read |=> (!rdy && !ardy));

  a_r4_cache_held_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && $past(!rdy)) |-> $stable(cache_page));

  a_r11_lun_err_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    lun_err |-> rdy);

  a_r12_reset_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reset |=> (rdy && ardy && col_ptr == '0 && !cache_vld));

  a_r8_cache_busy_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && lvl == LV_CACHE && (cmd_byte == OP_LAST || cmd_byte == OP_CONF_RD))
      |=> cmd_err);

endmodule

// File: tb/cache_read_seq_tb.sv
module cache_read_seq_tb;

  localparam int PB = 6, BB = 2, PL = 40, TR = 7, TRC = 3;
  localparam int RW = PB + BB, CW = $clog2(PL);

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cmd_valid = 1'b0, addr_valid = 1'b0, dout_req = 1'b0;
  logic [7:0]    cmd_byte = 8'h00, addr_byte = 8'h00;
  logic          rdy, ardy, cache_vld, cmd_err, lun_err, col_err;
  logic [RW-1:0] cache_page;
  logic [CW-1:0] col_ptr;

  int vectors = 0, fails = 0;

  always #2 clk = ~clk;

  cache_read_seq #(.PAGE_BITS(PB), .BLK_BITS(BB), .PAGE_LEN(PL), .T_R(TR), .T_RCBSY(TRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .addr_valid(addr_valid), .addr_byte(addr_byte), .dout_req(dout_req),
    .rdy(rdy), .ardy(ardy), .cache_vld(cache_vld), .cache_page(cache_page),
    .col_ptr(col_ptr), .cmd_err(cmd_err), .lun_err(lun_err), .col_err(col_err)
  );

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all drive tasks are entered at a negedge and return at the next one
  task automatic cmd(logic [7:0] op);
    cmd_valid = 1'b1; cmd_byte = op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic addr(logic [7:0] b);
    addr_valid = 1'b1; addr_byte = b;
    @(negedge clk);
    addr_valid = 1'b0;
  endtask

  task automatic dout();
    dout_req = 1'b1;
    @(negedge clk);
    dout_req = 1'b0;
  endtask

  task automatic count_full(output int n);
    n = 0;
    while (!rdy) begin n++; @(negedge clk); end
  endtask

  task automatic count_cache(output int n);
    n = 0;
    while (rdy && !ardy) begin n++; @(negedge clk); end
  endtask

  task automatic read_page(int row, int col);
    cmd(8'h00); addr(8'(col)); addr(8'(row)); cmd(8'h30);
  endtask

  // {block,page} successor computed from the fields
  function automatic int nxt(int r);
    int blk, pg;
    blk = r / 64; pg = r % 64;
    if (pg == 63) return (blk + 1) * 64;
    return blk * 64 + pg + 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int n, m, exp_data, exp_cache;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 rdy after reset", rdy, 1);
    check("R12 ardy after reset", ardy, 1);
    check("R12 cache_vld after reset", cache_vld, 0);
    check("R12 col after reset", col_ptr, 0);

    // R1 page read
    read_page(69, 5);
    count_full(n);
    check("R1 tR length", n, TR);
    check("R1 ardy after read", ardy, 1);
    check("R1 cache page", cache_page, 69);
    check("R1 column", col_ptr, 5);
    check("R12 cache_vld set", cache_vld, 1);

    // R5 column stepping and change, R6 saturation
    dout(); dout(); dout();
    check("R5 column steps", col_ptr, 8);
    cmd(8'h05); addr(8'd39); cmd(8'hE0);
    check("R5 column load", col_ptr, 39);
    check("R6 no err in range", col_err, 0);
    dout();
    check("R6 step at end", col_ptr, 39);
    check("R6 col_err on step", col_err, 1);
    cmd(8'h05); addr(8'd60); cmd(8'hE0);
    check("R6 load clamped", col_ptr, 39);
    check("R6 col_err on load", col_err, 1);
    cmd(8'h05); addr(8'd12); cmd(8'hE0);
    check("R5 column reload", col_ptr, 12);

    // R2 sequential timing
    cmd(8'h31);
    count_full(n);
    check("R2 tRCBSY length", n, TRC);
    check("R2 cache after 31", cache_page, 69);
    check("R5 column zero after 31", col_ptr, 0);
    count_cache(n);
    check("R2 cache-busy length", n, TR);
    check("R2 ready", rdy & ardy, 1);

    // R4 last
    cmd(8'h3F);
    count_full(n);
    check("R4 busy length", n, TRC);
    check("R4 cache after 3F", cache_page, 70);
    check("R4 ardy", ardy, 1);

    // R8 cache-busy legality
    cmd(8'h31);
    count_full(n);
    check("R8 cache-busy entered", {rdy, ardy}, 2);
    cmd(8'h3F);
    check("R8 3F rejected", cmd_err, 1);
    check("R8 still cache-busy", ardy, 0);
    cmd(8'h00); addr(8'd0); addr(8'd9);
    check("R8 00 and address accepted", cmd_err, 0);
    cmd(8'h30);
    check("R8 30 rejected", cmd_err, 1);
    while (!ardy) @(negedge clk);

    // R9 31 during cache-busy, R3 random fetch
    cmd(8'h31);
    count_full(n);
    check("R9 cache shows 71", cache_page, 71);
    cmd(8'h00); addr(8'd7); addr(8'd200); cmd(8'h31);
    count_full(n);
    check("R9 waits at least tRCBSY", (n + 1 >= TRC) ? 1 : 0, 1);
    check("R9 cache shows finished fetch", cache_page, 72);
    check("R3 column restart", col_ptr, 0);
    while (!ardy) @(negedge clk);
    cmd(8'h3F);
    count_full(n);
    check("R3 random page in cache", cache_page, 200);

    // R7 full-busy legality
    read_page(10, 0);
    cmd(8'h31);
    check("R7 31 rejected in busy", cmd_err, 1);
    cmd(8'h70);
    check("R7 70 accepted in busy", cmd_err, 0);
    cmd(8'h00);
    check("R7 00 rejected in busy", cmd_err, 1);
    cmd(8'h3F);
    check("R7 3F rejected in busy", cmd_err, 1);
    count_full(m);
    check("R7 tR unchanged", 4 + m, TR);
    check("R7 page read intact", cache_page, 10);

    // R13 malformed input
    cmd(8'h55);
    check("R13 unknown opcode", cmd_err, 1);
    addr(8'd3);
    check("R13 stray address", cmd_err, 1);
    cmd(8'h30);
    check("R13 30 without prefix", cmd_err, 1);
    cmd(8'hE0);
    check("R13 E0 without prefix", cmd_err, 1);
    cmd(8'h78);
    check("R13 status no error", cmd_err, 0);

    // R12 reset aborts busy
    read_page(20, 3);
    check("R12 busy before reset", rdy, 0);
    cmd(8'hFF);
    check("R12 rdy after FF", rdy, 1);
    check("R12 ardy after FF", ardy, 1);
    check("R12 col after FF", col_ptr, 0);
    check("R12 cache_vld after FF", cache_vld, 0);
    repeat (10) @(negedge clk);
    check("R12 stays ready", rdy & ardy, 1);

    // R2/R10/R11 sweep over every row of the die
    read_page(0, 0);
    count_full(n);
    exp_data = 0;
    for (int k = 1; k < 256; k++) begin
      exp_cache = exp_data;
      exp_data  = nxt(exp_data);
      cmd(8'h31);
      count_full(n);
      check("R2 sweep busy", n, TRC);
      if (exp_cache % 64 == 0 && exp_cache != 0)
        check("R10 block crossing", cache_page, exp_cache);
      else
        check("R2 sweep cache", cache_page, exp_cache);
      while (!ardy) @(negedge clk);
    end
    check("R10 sweep end row", exp_data, 255);
    cmd(8'h31);
    check("R11 lun_err", lun_err, 1);
    check("R11 no busy", rdy & ardy, 1);
    @(negedge clk);
    check("R11 lun_err clears", lun_err, 0);
    check("R11 cache unchanged", cache_page, 254);
    check("R11 still ready", rdy & ardy, 1);
    cmd(8'h3F);
    count_full(n);
    check("R4 final page", cache_page, 255);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule